// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is a single compare channel of a general-purpose timer. It receives the running count, the count direction and a counter clock-enable from the timer core. It holds a programmable compare value and a 3-bit output mode. From these it produces one active-high reference level. The reference drives a main output and a complementary output, and each output has its own polarity bit.

The compare value can be written in two ways. It can be written straight into the active register, or it can be written into a shadow copy that the timer's update event later transfers to the active register. An external clear input can hold the reference low when clearing is enabled. A protection level combined with the channel-mode selection can lock the mode field and the shadow enable against writes.

Top module: `tmr_cmp_chan`

## Requirements
- R1: While `rst` is high at a clock edge, the reference, the mode (frozen, 000), the shadow and active compare values, the shadow enable and the clear enable all become 0. `out_main` then equals `pol_main` and `out_comp` equals the inverse of `pol_comp`.
- R2: In mode 000 the reference keeps its value whatever the counter does. A configuration write takes effect from the clock edge that follows the write.
- R3: A match is `cnt_en`=1 together with `cnt_val` equal to the active compare value. On the edge of a match, mode 001 drives the reference to 1 and mode 010 drives it to 0. When there is no match, neither mode changes the reference, and this includes an equal count while `cnt_en`=0.
- R4: In mode 011 the reference inverts on every edge that has a match and holds its value otherwise.
- R5: Mode 100 drives the reference to 0 and mode 101 drives it to 1 at every edge, whatever the count.
- R6: In mode 110 the reference is evaluated at every edge. With `cnt_down`=0 it becomes 1 when `cnt_val` < compare, else 0. With `cnt_down`=1 it becomes 0 when `cnt_val` > compare, else 1.
- R7: Mode 111 yields the inverse of the mode 110 level for the same count, direction and compare value.
- R8: When the stored clear enable is 1, an edge with `etr_clr`=1 sets the reference to 0. This has priority over every mode. The mode behaviour resumes at the first edge with `etr_clr`=0.
- R9: When the stored shadow enable is 1, a `cv_we` write changes only the shadow copy. The active compare value takes the shadow copy at an edge with `upd_evt`=1.
- R10: When the stored shadow enable is 0, a `cv_we` write changes the active compare value at that edge.
- R11: While `prot_lvl`=11 and `chan_msel`=00, a `cfg_we` write leaves the mode and the shadow enable unchanged, but it still updates the clear enable. Any other combination accepts the whole write.
- R12: `out_main` = reference XOR `pol_main`, and `out_comp` = (NOT reference) XOR `pol_comp`. Both follow the polarity pins without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Counter clock-enable; qualifies matches |
| cnt_val | input | CNT_W | Current counter value |
| cnt_down | input | 1 | Count direction, 1 = down |
| upd_evt | input | 1 | Update event, loads active compare from shadow |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 3 | Output mode to write |
| cfg_shadow_en | input | 1 | Shadow enable to write |
| cfg_clr_en | input | 1 | External clear enable to write |
| prot_lvl | input | 2 | Protection level |
| chan_msel | input | 2 | Channel mode select, 00 = compare |
| cv_we | input | 1 | Compare value write strobe |
| cv_wdata | input | CNT_W | Compare value write data |
| pol_main | input | 1 | Main output polarity, 1 = active low |
| pol_comp | input | 1 | Complementary output polarity, 1 = active low |
| etr_clr | input | 1 | External clear input |
| ref_o | output | 1 | Active-high reference |
| out_main | output | 1 | Main output |
| out_comp | output | 1 | Complementary output |

## Verification
A wrong stored mode, clear enable or compare value produces a wrong reference at the first edge where the affected mode acts. For a forced mode or a PWM mode that is the very next edge. For set, clear and toggle modes it is the next matching edge, so the stimulus places matches soon after each configuration change. A shadow copy that leaks into the active register is exposed by the PWM level in the same cycle, before the update event. A lock that fails is exposed by the forced level written under lock.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

  localparam int unsigned ARITH_W = 32;

  typedef enum logic [2:0] {
    MODE_FROZEN = 3'b000,
    MODE_SET    = 3'b001,
    MODE_CLR    = 3'b010,
    MODE_TOG    = 3'b011,
    MODE_FLO    = 3'b100,
    MODE_FHI    = 3'b101,
    MODE_PWM0   = 3'b110,
    MODE_PWM1   = 3'b111
  } tcc_mode_e;

  // PWM level for a zero-extended count and compare value.
  function automatic logic pwm_level(input logic [ARITH_W-1:0] cnt,
                                     input logic [ARITH_W-1:0] cv,
                                     input logic down,
                                     input logic inv);
    logic hi;
    hi = down ? (cnt <= cv) : (cnt < cv);
    return hi ^ inv;
  endfunction

  function automatic logic cfg_locked(input logic [1:0] prot,
                                      input logic [1:0] msel);
    return (prot == 2'b11) && (msel == 2'b00);
  endfunction

endpackage

// File: rtl/tcc_cfg_regs.sv
module tcc_cfg_regs
  import tcc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      cfg_we,
  input  logic [2:0] cfg_mode,
  input  logic      cfg_shadow_en,
  input  logic      cfg_clr_en,
  input  logic [1:0] prot_lvl,
  input  logic [1:0] chan_msel,
  output tcc_mode_e mode_q,
  output logic      shadow_en_q,
  output logic      clr_en_q
);

  logic wr_blocked;
  assign wr_blocked = cfg_locked(prot_lvl, chan_msel);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= MODE_FROZEN;
      shadow_en_q <= 1'b0;
      clr_en_q    <= 1'b0;
    end else if (cfg_we) begin
      clr_en_q <= cfg_clr_en;
      if (!wr_blocked) begin
        mode_q      <= tcc_mode_e'(cfg_mode);
        shadow_en_q <= cfg_shadow_en;
      end
    end
  end

  a_r11_lock_holds: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && wr_blocked) |=> ($stable(mode_q) && $stable(shadow_en_q)));

  a_r11_open_write: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !wr_blocked) |=> (mode_q == $past(cfg_mode)));

endmodule

// File: rtl/tcc_cv_store.sv
module tcc_cv_store #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shadow_en,
  input  logic             cv_we,
  input  logic [CNT_W-1:0] cv_wdata,
  input  logic             upd_evt,
  output logic [CNT_W-1:0] cv_act,
  output logic [CNT_W-1:0] cv_shadow
);

  logic load_active;
  assign load_active = shadow_en && upd_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cv_shadow <= '0;
      cv_act    <= '0;
    end else begin
      if (cv_we) cv_shadow <= cv_wdata;
      if (load_active)            cv_act <= cv_shadow;
      else if (!shadow_en && cv_we) cv_act <= cv_wdata;
    end
  end

  a_r9_shadow_holds: assert property (@(posedge clk) disable iff (rst)
    (shadow_en && !upd_evt) |=> $stable(cv_act));

  a_r9_update_loads: assert property (@(posedge clk) disable iff (rst)
    (shadow_en && upd_evt) |=> (cv_act == $past(cv_shadow)));

  a_r10_direct_write: assert property (@(posedge clk) disable iff (rst)
    (!shadow_en && cv_we) |=> (cv_act == $past(cv_wdata)));

endmodule

// File: rtl/tcc_ref_gen.sv
module tcc_ref_gen
  import tcc_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  tcc_mode_e        mode,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_down,
  input  logic [CNT_W-1:0] cv_act,
  input  logic             clr_en,
  input  logic             etr_clr,
  output logic             ref_q
);

  logic cmp_hit;
  logic clr_hold;
  logic pwm_lvl;
  logic ref_nxt;

  assign cmp_hit  = cnt_en && (cnt_val == cv_act);
  assign clr_hold = clr_en && etr_clr;
  assign pwm_lvl  = pwm_level(ARITH_W'(cnt_val), ARITH_W'(cv_act), cnt_down,
                              mode == MODE_PWM1);

  always_comb begin
    ref_nxt = ref_q;
    if (clr_hold) begin
      ref_nxt = 1'b0;
    end else begin
      unique case (mode)
        MODE_FROZEN: ref_nxt = ref_q;
        MODE_SET:    if (cmp_hit) ref_nxt = 1'b1;
        MODE_CLR:    if (cmp_hit) ref_nxt = 1'b0;
        MODE_TOG:    if (cmp_hit) ref_nxt = !ref_q;
        MODE_FLO:    ref_nxt = 1'b0;
        MODE_FHI:    ref_nxt = 1'b1;
        MODE_PWM0,
        MODE_PWM1:   ref_nxt = pwm_lvl;
        default:     ref_nxt = ref_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ref_q <= 1'b0;
    else     ref_q <= ref_nxt;
  end

  a_r2_frozen_holds: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_FROZEN && !clr_hold) |=> $stable(ref_q));

  a_r3_set_on_hit: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SET && cmp_hit && !clr_hold) |=> ref_q);

  a_r3_no_hit_no_change: assert property (@(posedge clk) disable iff (rst)
    ((mode == MODE_SET || mode == MODE_CLR) && !cmp_hit && !clr_hold) |=> $stable(ref_q));

  a_r4_toggle_flips: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_TOG && cmp_hit && !clr_hold) |=> (ref_q != $past(ref_q)));

  a_r5_force_low: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_FLO) |=> !ref_q);

  a_r5_force_high: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_FHI && !clr_hold) |=> ref_q);

  a_r8_clear_wins: assert property (@(posedge clk) disable iff (rst)
    clr_hold |=> !ref_q);

endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan
  import tcc_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_down,
  input  logic             upd_evt,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_mode,
  input  logic             cfg_shadow_en,
  input  logic             cfg_clr_en,
  input  logic [1:0]       prot_lvl,
  input  logic [1:0]       chan_msel,
  input  logic             cv_we,
  input  logic [CNT_W-1:0] cv_wdata,
  input  logic             pol_main,
  input  logic             pol_comp,
  input  logic             etr_clr,
  output logic             ref_o,
  output logic             out_main,
  output logic             out_comp
);

  tcc_mode_e        mode_q;
  logic             shadow_en_q;
  logic             clr_en_q;
  logic [CNT_W-1:0] cv_act;
  logic [CNT_W-1:0] cv_shadow;

  tcc_cfg_regs u_cfg (
    .clk           (clk),
    .rst           (rst),
    .cfg_we        (cfg_we),
    .cfg_mode      (cfg_mode),
    .cfg_shadow_en (cfg_shadow_en),
    .cfg_clr_en    (cfg_clr_en),
    .prot_lvl      (prot_lvl),
    .chan_msel     (chan_msel),
    .mode_q        (mode_q),
    .shadow_en_q   (shadow_en_q),
    .clr_en_q      (clr_en_q)
  );

  tcc_cv_store #(.CNT_W(CNT_W)) u_cv (
    .clk       (clk),
    .rst       (rst),
    .shadow_en (shadow_en_q),
    .cv_we     (cv_we),
    .cv_wdata  (cv_wdata),
    .upd_evt   (upd_evt),
    .cv_act    (cv_act),
    .cv_shadow (cv_shadow)
  );

  tcc_ref_gen #(.CNT_W(CNT_W)) u_ref (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode_q),
    .cnt_en   (cnt_en),
    .cnt_val  (cnt_val),
    .cnt_down (cnt_down),
    .cv_act   (cv_act),
    .clr_en   (clr_en_q),
    .etr_clr  (etr_clr),
    .ref_q    (ref_o)
  );

  assign out_main = ref_o ^ pol_main;
  assign out_comp = (!ref_o) ^ pol_comp;

endmodule

// File: tb/tmr_cmp_chan_bench.sv
`timescale 1ns/100ps
module tmr_cmp_chan_bench;

  localparam int W = 16;

  logic clk = 1'b0;
  logic rst, cnt_en, cnt_down, upd_evt, cfg_we, cfg_shadow_en, cfg_clr_en;
  logic cv_we, pol_main, pol_comp, etr_clr;
  logic [2:0] cfg_mode;
  logic [1:0] prot_lvl, chan_msel;
  logic [W-1:0] cnt_val, cv_wdata;
  logic ref_o, out_main, out_comp;

  always #2.5 clk = ~clk;

  tmr_cmp_chan #(.CNT_W(W)) u_tmr_cmp_chan (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .cnt_val(cnt_val), .cnt_down(cnt_down),
    .upd_evt(upd_evt), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_shadow_en(cfg_shadow_en), .cfg_clr_en(cfg_clr_en), .prot_lvl(prot_lvl),
    .chan_msel(chan_msel), .cv_we(cv_we), .cv_wdata(cv_wdata), .pol_main(pol_main),
    .pol_comp(pol_comp), .etr_clr(etr_clr), .ref_o(ref_o), .out_main(out_main),
    .out_comp(out_comp)
  );

  typedef struct { logic r; logic m; logic c; string tag; } exp_t;
  exp_t sb[$];
  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Reference model state, written from the requirements.
  logic       m_ref, m_shen, m_clren;
  logic [2:0] m_mode;
  logic [W-1:0] m_sh, m_act;

  // Monitor: one scoreboard item per clock, compared at the falling edge.
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (ref_o !== e.r || out_main !== e.m || out_comp !== e.c) begin
        failures++;
        $display("FAIL %s: ref/main/comp actual=%b%b%b expected=%b%b%b",
                 e.tag, ref_o, out_main, out_comp, e.r, e.m, e.c);
      end
    end
  end

  // Driver: advance model one edge, push expectation, wait one clock.
  task automatic cyc(input string tag);
    logic hit, lvl, nref;
    exp_t e;
    if (rst) begin
      m_ref = 0; m_mode = 3'b000; m_sh = '0; m_act = '0; m_shen = 0; m_clren = 0;
    end else begin
      hit = cnt_en && (cnt_val == m_act);
      lvl = cnt_down ? !(cnt_val > m_act) : (cnt_val < m_act);
      nref = m_ref;
      if (m_clren && etr_clr) nref = 0;
      else case (m_mode)
        3'b001: if (hit) nref = 1;
        3'b010: if (hit) nref = 0;
        3'b011: if (hit) nref = !m_ref;
        3'b100: nref = 0;
        3'b101: nref = 1;
        3'b110: nref = lvl;
        3'b111: nref = !lvl;
        default: nref = m_ref;
      endcase
      if (m_shen && upd_evt) m_act = m_sh;
      else if (!m_shen && cv_we) m_act = cv_wdata;
      if (cv_we) m_sh = cv_wdata;
      if (cfg_we) begin
        m_clren = cfg_clr_en;
        if (!(prot_lvl == 2'b11 && chan_msel == 2'b00)) begin
          m_mode = cfg_mode; m_shen = cfg_shadow_en;
        end
      end
      m_ref = nref;
    end
    e.r = m_ref; e.m = m_ref ^ pol_main; e.c = !m_ref ^ pol_comp; e.tag = tag;
    sb.push_back(e);
    @(negedge clk); #1;
    cfg_we = 0; cv_we = 0; upd_evt = 0;
  endtask

  task automatic set_cfg(input logic [2:0] md, input logic sh, input logic ce, input string tag);
    cfg_we = 1; cfg_mode = md; cfg_shadow_en = sh; cfg_clr_en = ce; cyc(tag);
  endtask

  task automatic wr_cv(input logic [W-1:0] v, input string tag);
    cv_we = 1; cv_wdata = v; cyc(tag);
  endtask

  task automatic count(input logic [W-1:0] v, input logic en, input logic dn, input string tag);
    cnt_val = v; cnt_en = en; cnt_down = dn; cyc(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1; cnt_en = 0; cnt_down = 0; upd_evt = 0; cfg_we = 0; cfg_shadow_en = 0;
    cfg_clr_en = 0; cv_we = 0; pol_main = 0; pol_comp = 0; etr_clr = 0;
    cfg_mode = 3'b000; prot_lvl = 2'b00; chan_msel = 2'b00; cnt_val = '0; cv_wdata = '0;
    @(negedge clk); #1;
    cyc("R1 reset"); cyc("R1 reset");
    pol_main = 1; pol_comp = 1; cyc("R1 reset polarity");
    rst = 0; pol_main = 0; pol_comp = 0;
    // R10: direct compare write
    wr_cv(16'd10, "R10 direct write");
    // R2: frozen ignores a match
    count(16'd10, 1, 0, "R2 frozen");
    count(16'd10, 1, 0, "R2 frozen");
    // R3: set / clear on match only
    set_cfg(3'b001, 0, 0, "R2 cfg next edge");
    count(16'd10, 0, 0, "R3 no enable");
    count(16'd5, 1, 0, "R3 no match");
    count(16'd10, 1, 0, "R3 set on match");
    count(16'd11, 1, 0, "R3 hold");
    set_cfg(3'b010, 0, 0, "R3 cfg clr");
    count(16'd9, 1, 0, "R3 no match");
    count(16'd10, 1, 0, "R3 clear on match");
    // R4: toggle
    set_cfg(3'b011, 0, 0, "R4 cfg");
    count(16'd10, 1, 0, "R4 toggle");
    count(16'd10, 0, 0, "R4 no enable");
    count(16'd10, 1, 0, "R4 toggle");
    count(16'd10, 1, 1, "R4 toggle down");
    // R5: forced levels
    set_cfg(3'b101, 0, 0, "R5 cfg");
    count(16'd3, 0, 0, "R5 force high");
    set_cfg(3'b100, 0, 0, "R5 cfg");
    count(16'd3, 1, 0, "R5 force low");
    // R6: PWM mode 0 both directions
    set_cfg(3'b110, 0, 0, "R6 cfg");
    for (int i = 7; i <= 13; i++) count(W'(i), 1, 0, "R6 pwm0 up");
    for (int i = 13; i >= 7; i--) count(W'(i), 1, 1, "R6 pwm0 down");
    // R7: PWM mode 1
    set_cfg(3'b111, 0, 0, "R7 cfg");
    for (int i = 7; i <= 13; i++) count(W'(i), 1, 0, "R7 pwm1 up");
    for (int i = 13; i >= 7; i--) count(W'(i), 1, 1, "R7 pwm1 down");
    // R8: external clear, disabled then enabled
    set_cfg(3'b101, 0, 0, "R8 cfg");
    etr_clr = 1; cyc("R8 clear disabled");
    etr_clr = 0;
    set_cfg(3'b101, 0, 1, "R8 cfg enable");
    etr_clr = 1; cyc("R8 clear held"); cyc("R8 clear held");
    etr_clr = 0; cyc("R8 resume");
    // R9: shadow write waits for update
    set_cfg(3'b110, 1, 0, "R9 cfg");
    wr_cv(16'd20, "R9 shadow write");
    count(16'd15, 1, 0, "R9 old compare");
    count(16'd15, 1, 0, "R9 old compare");
    upd_evt = 1; cyc("R9 update edge");
    count(16'd15, 1, 0, "R9 new compare");
    // R11: lock blocks mode, clear enable still written
    prot_lvl = 2'b11; chan_msel = 2'b00;
    set_cfg(3'b100, 0, 1, "R11 locked write");
    count(16'd25, 1, 0, "R11 mode kept");
    count(16'd5, 1, 0, "R11 mode kept");
    etr_clr = 1; cyc("R11 clear enable written");
    etr_clr = 0; cyc("R11 resume");
    chan_msel = 2'b01;
    set_cfg(3'b100, 0, 0, "R11 unlocked write");
    count(16'd5, 1, 0, "R11 mode changed");
    // R12: polarity combinations
    prot_lvl = 2'b00; chan_msel = 2'b00;
    set_cfg(3'b101, 0, 0, "R12 cfg");
    for (int p = 0; p < 4; p++) begin
      pol_main = p[0]; pol_comp = p[1]; cyc("R12 polarity high ref");
    end
    set_cfg(3'b100, 0, 0, "R12 cfg");
    for (int p = 0; p < 4; p++) begin
      pol_main = p[0]; pol_comp = p[1]; cyc("R12 polarity low ref");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule